// File: doc/BRIEF.md
# Halt and Wake-Up Controller

This block runs on an always-on clock beside a small processor core and manages the low-power halt state. When the sequencer reports that a halt instruction has executed, the controller drops the system clock enable, sets the power-down flag and clears the timeout flag. While the core sleeps, the controller watches four wake sources: an external reset request, an interrupt request that was not already pending at halt entry, a falling edge on any port pin that is selected for wake-up, and a watchdog overflow.

When a source fires, the clock enable returns at once. The controller then holds the core in a fixed restart delay of 1024 system clocks so that the oscillator can settle. After the delay it gives one pulse to the sequencer. The pulse carries an action code that tells the sequencer what to do next: continue at the next instruction, enter an interrupt vector, perform a warm reset (program counter and stack pointer only) or perform a full reset. When the action is a vector, the pulse also carries the number of the interrupt.

Top module: `haltWakeUnit`

## Requirements
- R1: After reset, sysClkEn is 1, pdfFlag is 0, toFlag is 0 and actValid is 0.
- R2: A haltStrobe while the core is running gates the clock: sysClkEn is 0 from the next cycle, pdfFlag becomes 1 and toFlag becomes 0.
- R3: clrWdtStrobe clears pdfFlag on the next cycle.
- R4: While halted, extRstReq, wdtOverflow or a wake-capable interrupt is sampled on the next clock edge, and sysClkEn returns to 1 after that edge. Each port pin passes through a two-flop synchronizer. A 1-to-0 transition on a pin whose portWakeMask bit is 1 re-enables the clock three edges after the pin changes. A rising edge, or a fall on an unmasked pin, leaves the core halted.
- R5: actValid pulses for exactly one cycle, 1024 cycles after sysClkEn has returned to 1. The following cycle runs normally.
- R6: When several wake sources are present in the sampled cycle, the action is chosen by priority: external reset gives actCode 3 (full reset), watchdog overflow gives 2 (warm reset), then the interrupt, then the port edge. A port wake gives 0 (continue at next instruction).
- R7: An irqReq bit that is already 1 on the edge that takes the halt cannot wake the core. If that bit drops to 0 while halted and later returns to 1, it can wake the core.
- R8: On an interrupt wake, actCode is 1 (vector) when at least one waking interrupt has its irqEn bit set and stackFull is 0. actIrqIdx is then the lowest such index. Otherwise actCode is 0 and actIrqIdx is 0.
- R9: wdtOverflow sets toFlag on the next cycle in any state. Halt entry is the only thing that clears toFlag.
- R10: During the restart delay, further wake inputs and haltStrobe do not change the pending action or the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| haltStrobe | input | 1 | Halt instruction executed |
| clrWdtStrobe | input | 1 | Watchdog-clear instruction executed |
| extRstReq | input | 1 | External reset request (wake source) |
| wdtOverflow | input | 1 | Watchdog overflow pulse |
| irqReq | input | IRQ_N | Interrupt request flags |
| irqEn | input | IRQ_N | Interrupt enables |
| stackFull | input | 1 | Return stack has no free entry |
| portPins | input | PORT_W | Raw port pins |
| portWakeMask | input | PORT_W | Per-pin wake-up selection |
| sysClkEn | output | 1 | System clock enable (0 while halted) |
| pdfFlag | output | 1 | Power-down flag |
| toFlag | output | 1 | Watchdog timeout flag |
| actValid | output | 1 | One-cycle resume action strobe |
| actCode | output | 2 | 0 next instr, 1 vector, 2 warm reset, 3 full reset |
| actIrqIdx | output | IDX_W | Interrupt number for a vector action |

## Verification
The direct wake sources re-enable the clock one edge after they are driven, and a port fall does so three edges after the pin changes. The bench measures this latency in whole cycles, sampling at falling edges, and compares it with the value expected for the source that should win. It then counts cycles from the re-enabled clock to actValid and expects exactly 1024. In that same cycle it compares the action code, the interrupt number and toFlag with values from bench functions, and one cycle later it checks that the pulse has ended. The flag results of the halt and clear strobes are sampled on the falling edge after the edge that takes them.

// File: rtl/haltWakePkg.sv
package haltWakePkg;

  typedef enum logic [1:0] {
    ACT_RESUME = 2'd0,
    ACT_VECTOR = 2'd1,
    ACT_WARM   = 2'd2,
    ACT_COLD   = 2'd3
  } actCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enterHalt;   // halt taken this cycle
    logic latchCause;  // wake accepted this cycle
    logic inHalt;      // clock currently gated
  } ctrlStrb_t;

endpackage

// File: rtl/haltWakeCtrl.sv
module haltWakeCtrl
  import haltWakePkg::*;
#(
  parameter int DELAY_CYC = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      haltStrobe,
  input  logic      wakeAny,
  output ctrlStrb_t strb,
  output logic      sysClkEn,
  output logic      actValid
);

  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(DELAY_CYC - 1);

  typedef enum logic [1:0] {S_RUN, S_HALTED, S_WAIT, S_ISSUE} state_e;

  state_e          state;
  logic [CNT_W-1:0] delayCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_RUN;
      delayCnt <= '0;
    end else begin
      unique case (state)
        S_RUN:    if (haltStrobe) state <= S_HALTED;
        S_HALTED: if (wakeAny) begin
                    state    <= S_WAIT;
                    delayCnt <= '0;
                  end
        S_WAIT:   if (delayCnt == TERM) state <= S_ISSUE;
                  else delayCnt <= delayCnt + 1'b1;
        S_ISSUE:  state <= S_RUN;
        default:  state <= S_RUN;
      endcase
    end
  end

  always_comb begin
    strb.enterHalt  = (state == S_RUN) && haltStrobe;
    strb.latchCause = (state == S_HALTED) && wakeAny;
    strb.inHalt     = (state == S_HALTED);
  end

  assign sysClkEn = (state != S_HALTED);
  assign actValid = (state == S_ISSUE);

  // R2: clock is gated on the cycle after a halt is taken
  a_r2_gate_after_halt: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_RUN) && haltStrobe) |=> !sysClkEn);

  // R4: accepted wake restores the clock and restarts the delay count
  a_r4_wake_reenables: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_HALTED) && wakeAny) |=> (sysClkEn && delayCnt == '0));

  // R5: the delay counter advances by one each waiting cycle
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_WAIT) && (delayCnt != TERM)) |=> (delayCnt == $past(delayCnt) + 1'b1));

  // R5: the action strobe lasts a single cycle and returns to running
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    actValid |=> (!actValid && sysClkEn));

  // R10: waiting cannot fall back into halt
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |=> (state == S_WAIT || state == S_ISSUE));

endmodule

// File: rtl/haltWakeDatapath.sv
module haltWakeDatapath
  import haltWakePkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IRQ_N  = 2,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              clrWdtStrobe,
  input  logic              extRstReq,
  input  logic              wdtOverflow,
  input  logic [IRQ_N-1:0]  irqReq,
  input  logic [IRQ_N-1:0]  irqEn,
  input  logic              stackFull,
  input  logic [PORT_W-1:0] portPins,
  input  logic [PORT_W-1:0] portWakeMask,
  output logic              wakeAny,
  output logic              pdfFlag,
  output logic              toFlag,
  output logic [1:0]        actCode,
  output logic [IDX_W-1:0]  actIrqIdx
);

  // port synchronizer and previous-value copy
  logic [PORT_W-1:0] portS1, portS2, portPrev, fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portS1   <= '1;
      portS2   <= '1;
      portPrev <= '1;
    end else begin
      portS1   <= portPins;
      portS2   <= portS1;
      portPrev <= portS2;
    end
  end

  assign fallEdge = portPrev & ~portS2 & portWakeMask;

  // interrupts pending at halt entry may not wake the core
  logic [IRQ_N-1:0] irqBlocked, irqWake, irqTake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               irqBlocked <= '0;
    else if (strb.enterHalt) irqBlocked <= irqReq;
    else if (strb.inHalt)    irqBlocked <= irqBlocked & irqReq;
  end

  assign irqWake = irqReq & ~irqBlocked;
  assign irqTake = irqWake & irqEn;
  assign wakeAny = extRstReq | wdtOverflow | (|irqWake) | (|fallEdge);

  // cause arbitration
  actCode_e       nextCode;
  logic [IDX_W-1:0] lowIdx;

  always_comb begin
    lowIdx = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (irqTake[i]) lowIdx = IDX_W'(i);
    end
  end

  always_comb begin
    if (extRstReq)        nextCode = ACT_COLD;
    else if (wdtOverflow) nextCode = ACT_WARM;
    else if (|irqWake)    nextCode = ((|irqTake) && !stackFull) ? ACT_VECTOR : ACT_RESUME;
    else                  nextCode = ACT_RESUME;
  end

  actCode_e         codeQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= ACT_RESUME;
      idxQ  <= '0;
    end else if (strb.latchCause) begin
      codeQ <= nextCode;
      idxQ  <= (nextCode == ACT_VECTOR) ? lowIdx : '0;
    end
  end

  assign actCode   = codeQ;
  assign actIrqIdx = idxQ;

  // status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdfFlag <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      if (strb.enterHalt)   pdfFlag <= 1'b1;
      else if (clrWdtStrobe) pdfFlag <= 1'b0;
      if (wdtOverflow)      toFlag <= 1'b1;
      else if (strb.enterHalt) toFlag <= 1'b0;
    end
  end

  // R2: the power-down flag only rises through halt entry
  a_r2_pdf_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdfFlag) |-> $past(strb.enterHalt));

  // R3: a clear strobe outside halt entry leaves the flag low
  a_r3_pdf_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrWdtStrobe && !strb.enterHalt) |=> !pdfFlag);

  // R9: watchdog overflow always marks a timeout
  a_r9_to_set: assert property (@(posedge clk) disable iff (!rstN)
    wdtOverflow |=> toFlag);

  // R6: external reset outranks every other cause
  a_r6_ext_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchCause && extRstReq) |=> (actCode == 2'd3));

  // R8: a full stack never yields a vector action
  a_r8_stack_full: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchCause && stackFull) |=> (actCode != 2'd1));

endmodule

// File: rtl/haltWakeUnit.sv
module haltWakeUnit
  import haltWakePkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int IRQ_N     = 2,
  parameter int DELAY_CYC = 1024,
  localparam int IDX_W    = (IRQ_N > 1) ? $clog2(IRQ_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltStrobe,
  input  logic              clrWdtStrobe,
  input  logic              extRstReq,
  input  logic              wdtOverflow,
  input  logic [IRQ_N-1:0]  irqReq,
  input  logic [IRQ_N-1:0]  irqEn,
  input  logic              stackFull,
  input  logic [PORT_W-1:0] portPins,
  input  logic [PORT_W-1:0] portWakeMask,
  output logic              sysClkEn,
  output logic              pdfFlag,
  output logic              toFlag,
  output logic              actValid,
  output logic [1:0]        actCode,
  output logic [IDX_W-1:0]  actIrqIdx
);

  ctrlStrb_t strb;
  logic      wakeAny;

  haltWakeCtrl #(.DELAY_CYC(DELAY_CYC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .haltStrobe (haltStrobe),
    .wakeAny    (wakeAny),
    .strb       (strb),
    .sysClkEn   (sysClkEn),
    .actValid   (actValid)
  );

  haltWakeDatapath #(.PORT_W(PORT_W), .IRQ_N(IRQ_N), .IDX_W(IDX_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .clrWdtStrobe (clrWdtStrobe),
    .extRstReq    (extRstReq),
    .wdtOverflow  (wdtOverflow),
    .irqReq       (irqReq),
    .irqEn        (irqEn),
    .stackFull    (stackFull),
    .portPins     (portPins),
    .portWakeMask (portWakeMask),
    .wakeAny      (wakeAny),
    .pdfFlag      (pdfFlag),
    .toFlag       (toFlag),
    .actCode      (actCode),
    .actIrqIdx    (actIrqIdx)
  );

endmodule

// File: tb/haltWakeUnit_bench.sv
`timescale 1ns/1ps
module haltWakeUnit_bench;

  localparam int PORT_W = 8;
  localparam int IRQ_N  = 2;
  localparam int DELAY  = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltStrobe = 0, clrWdtStrobe = 0, extRstReq = 0, wdtOverflow = 0, stackFull = 0;
  logic [IRQ_N-1:0]  irqReq = '0, irqEn = '0;
  logic [PORT_W-1:0] portPins = '1, portWakeMask = '0;
  logic sysClkEn, pdfFlag, toFlag, actValid;
  logic [1:0] actCode;
  logic [0:0] actIrqIdx;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  haltWakeUnit #(.PORT_W(PORT_W), .IRQ_N(IRQ_N), .DELAY_CYC(DELAY)) u_haltWakeUnit (
    .clk(clk), .rstN(rstN), .haltStrobe(haltStrobe), .clrWdtStrobe(clrWdtStrobe),
    .extRstReq(extRstReq), .wdtOverflow(wdtOverflow), .irqReq(irqReq), .irqEn(irqEn),
    .stackFull(stackFull), .portPins(portPins), .portWakeMask(portWakeMask),
    .sysClkEn(sysClkEn), .pdfFlag(pdfFlag), .toFlag(toFlag), .actValid(actValid),
    .actCode(actCode), .actIrqIdx(actIrqIdx)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expCode(bit ext, bit wdt, logic [IRQ_N-1:0] woken,
                                 logic [IRQ_N-1:0] en, bit sfull);
    if (ext) return 3;
    if (wdt) return 2;
    if (woken != 0) return (((woken & en) != 0) && !sfull) ? 1 : 0;
    return 0;
  endfunction

  function automatic int expIdx(logic [IRQ_N-1:0] take);
    for (int i = 0; i < IRQ_N; i++) if (take[i]) return i;
    return 0;
  endfunction

  task automatic enterHalt(input logic [IRQ_N-1:0] pre);
    @(negedge clk);
    irqReq = pre;
    haltStrobe = 1'b1;
    @(negedge clk);
    haltStrobe = 1'b0;
    check(sysClkEn == 1'b0, "R2", "clock gated", int'(sysClkEn), 0);
    check(pdfFlag == 1'b1, "R2", "pdf set", int'(pdfFlag), 1);
    check(toFlag == 1'b0, "R2", "to cleared", int'(toFlag), 0);
  endtask

  task automatic stayHalted(input int n, input string req);
    repeat (n) @(negedge clk);
    check(sysClkEn == 1'b0, req, "still halted", int'(sysClkEn), 0);
  endtask

  task automatic wakeRun(input bit ext, input bit wdt, input logic [IRQ_N-1:0] pre,
                         input logic [IRQ_N-1:0] newIrq, input logic [IRQ_N-1:0] en,
                         input bit sfull, input logic [PORT_W-1:0] fallBits,
                         input logic [PORT_W-1:0] mask, input bit disturb);
    logic [IRQ_N-1:0] woken;
    int code, idx, expLat, lat, n;
    woken  = newIrq & ~pre;
    code   = expCode(ext, wdt, woken, en, sfull);
    idx    = (code == 1) ? expIdx(woken & en) : 0;
    expLat = (ext || wdt || woken != 0) ? 1 : 3;
    irqEn = en; stackFull = sfull; portWakeMask = mask;
    extRstReq = ext; wdtOverflow = wdt;
    irqReq = pre | newIrq;
    portPins = portPins & ~fallBits;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      extRstReq = 1'b0; wdtOverflow = 1'b0;
    end while (!sysClkEn && lat < 8);
    check(lat == expLat, "R4", "wake latency", lat, expLat);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (disturb && n == 100) begin haltStrobe = 1'b1; extRstReq = 1'b1; portPins = '0; end
      if (disturb && n == 101) begin haltStrobe = 1'b0; extRstReq = 1'b0; end
    end while (!actValid && n < DELAY + 20);
    check(n == DELAY, disturb ? "R10" : "R5", "delay cycles", n, DELAY);
    check(int'(actCode) == code, (woken != 0 && !ext && !wdt) ? "R8" : "R6", "action code", int'(actCode), code);
    if (code == 1) check(int'(actIrqIdx) == idx, "R8", "irq index", int'(actIrqIdx), idx);
    check(toFlag == wdt, "R9", "timeout flag after wake", int'(toFlag), int'(wdt));
    @(negedge clk);
    check(actValid == 1'b0 && sysClkEn == 1'b1, "R5", "pulse ended", int'(actValid), 0);
    irqReq = '0; portPins = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sysClkEn == 1'b1, "R1", "clock on", int'(sysClkEn), 1);
    check(pdfFlag == 1'b0, "R1", "pdf idle", int'(pdfFlag), 0);
    check(toFlag == 1'b0, "R1", "to idle", int'(toFlag), 0);
    check(actValid == 1'b0, "R1", "no action", int'(actValid), 0);

    // R9: overflow while running
    wdtOverflow = 1'b1;
    @(negedge clk);
    wdtOverflow = 1'b0;
    check(toFlag == 1'b1, "R9", "to set while running", int'(toFlag), 1);

    // R7 and R4: blocked interrupt, unmasked fall and rising edge do not wake
    enterHalt(2'b01);
    stayHalted(20, "R7");
    portWakeMask = 8'h0F;
    portPins = 8'h7F;
    stayHalted(10, "R4");
    portPins = 8'hFF;
    stayHalted(10, "R4");
    haltStrobe = 1'b1;
    @(negedge clk);
    haltStrobe = 1'b0;
    irqReq = 2'b00;
    stayHalted(3, "R7");
    wakeRun(0, 0, 2'b00, 2'b01, 2'b11, 0, '0, 8'h0F, 0);
    clrWdtStrobe = 1'b1;
    @(negedge clk);
    clrWdtStrobe = 1'b0;
    check(pdfFlag == 1'b0, "R3", "pdf cleared", int'(pdfFlag), 0);

    // R8: full stack gives resume; R8 higher enabled index
    enterHalt(2'b00);
    wakeRun(0, 0, 2'b00, 2'b11, 2'b11, 1, '0, '0, 0);
    enterHalt(2'b00);
    wakeRun(0, 0, 2'b00, 2'b11, 2'b10, 0, '0, '0, 0);

    // R6: all sources at once; R10 disturbed delay; port-only wake
    enterHalt(2'b00);
    wakeRun(1, 1, 2'b00, 2'b01, 2'b01, 0, 8'h01, 8'h01, 0);
    enterHalt(2'b00);
    wakeRun(0, 0, 2'b00, 2'b00, 2'b00, 0, 8'h04, 8'h04, 1);
    enterHalt(2'b10);
    wakeRun(0, 1, 2'b10, 2'b10, 2'b11, 0, 8'h10, 8'h10, 0);

    for (int it = 0; it < 40; it++) begin
      logic [IRQ_N-1:0] pre, nw, en;
      logic [PORT_W-1:0] fb, mk;
      bit ext, wdt, sf;
      pre = IRQ_N'($urandom);
      nw  = IRQ_N'($urandom);
      en  = IRQ_N'($urandom);
      fb  = PORT_W'($urandom);
      mk  = PORT_W'($urandom);
      ext = ($urandom % 6) == 0;
      wdt = ($urandom % 4) == 0;
      sf  = ($urandom % 3) == 0;
      if (($urandom % 2) == 0) nw = '0;
      if (!ext && !wdt && (nw & ~pre) == 0 && (fb & mk) == 0) wdt = 1'b1;
      enterHalt(pre);
      stayHalted(int'($urandom % 4), "R7");
      wakeRun(ext, wdt, pre, nw, en, sf, fb, mk, 0);
      if (($urandom % 2) == 0) begin
        clrWdtStrobe = 1'b1;
        @(negedge clk);
        clrWdtStrobe = 1'b0;
        check(pdfFlag == 1'b0, "R3", "pdf cleared random", int'(pdfFlag), 0);
      end
      repeat (4) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule